// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block keeps, for each DMA channel, a base and a current copy of the memory address and of the transfer word count. Whenever the surrounding controller finishes one transfer on the channel in service, it pulses a strobe. The unit then steps that channel's current count down by one and moves its current address up or down by one, according to the channel's direction setting. The current address of the channel in service is driven out continuously for the address bus.

A channel's service ends in one of two ways. The first is a terminal count, which happens when a strobe arrives while the current count is already zero, so the count wraps to all ones. The second is an external end-of-process flag given together with the strobe. When service ends, the unit sends out a one-cycle end-of-process pulse. If the channel is set to autoinitialize, it then reloads both current registers from the base registers. If not, it sets the channel's mask bit. A terminal count also sets the channel's sticky status bit, and a status read clears all of these bits.

Between bursts the current registers hold their values untouched, so a demand-style service picks up where it left off. Bus arbitration and strobe timing are handled elsewhere.

Top module: `dma_addr_count_unit`

## Requirements
- R1: After reset every current and base register is zero, every channel's direction is increment with autoinitialize off, all mask bits are 1, all status bits are 0 and `eop_out` is 0.
- R2: A write with `wr_sel`=0 loads the channel's base and current address; with `wr_sel`=1 it loads the base and current count; both take `wr_data` and are visible on the next cycle.
- R3: Each strobe without an end of service decrements the serviced channel's current count by exactly one.
- R4: Each strobe steps the current address by +1 when the channel's `mode_dec`=0 and by -1 when `mode_dec`=1, wrapping modulo 2^16 (0000H-1 gives FFFFH).
- R5: A strobe while the current count is 0000H is a terminal count: status bit `tc_status[ch]` is set and `eop_out` is 1 for exactly the one cycle after that strobe's edge.
- R6: At an end of service on a channel with `mode_auto`=1, both current registers are reloaded from the base registers and the mask bit is left unchanged.
- R7: At an end of service on a channel with `mode_auto`=0, the channel's mask bit is set and the current registers take their stepped values (count FFFFH after a terminal count).
- R8: `ext_eop` together with a strobe ends service like R6/R7 and pulses `eop_out`, but does not set the status bit.
- R9: A cycle with `stat_rd`=1 clears all status bits, except that a terminal count in that same cycle still sets its bit.
- R10: Without a strobe or a write, current registers keep their values; a strobe changes only the channel selected by `svc_ch`.
- R11: Bit i of `mask_clr` clears mask bit i; a mask set from R7 in the same cycle takes priority.
- R12: A register write to a channel in the same cycle as a strobe to that channel takes effect, and the strobe is ignored for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_sel | input | 1 | 0 = address register, 1 = count register |
| wr_data | input | 16 | Value written to base and current copy |
| mode_wr | input | 1 | Mode write enable |
| mode_ch | input | 2 | Channel addressed by the mode write |
| mode_dec | input | 1 | Direction: 1 = address decrements |
| mode_auto | input | 1 | Autoinitialize enable |
| mask_clr | input | 4 | Per-channel mask clear |
| stat_rd | input | 1 | Status read; clears status bits |
| svc_ch | input | 2 | Channel in service |
| xfer_stb | input | 1 | One transfer completed on `svc_ch` |
| ext_eop | input | 1 | External end of process, qualified by `xfer_stb` |
| addr_out | output | 16 | Current address of `svc_ch` |
| cnt_out | output | 16 | Current count of `svc_ch` |
| eop_out | output | 1 | One-cycle end-of-process pulse |
| tc_status | output | 4 | Sticky terminal-count bits |
| mask_out | output | 4 | Channel mask bits |

## Verification
The bench targets the wrap of the count from zero. A design that flags completion when the count reaches zero would end service one transfer early and show 0000H where FFFFH is expected. It also tests address wrap in the decrement direction, and a mistake there shows up as a wrong value at 0000H. For autoinitialize it checks that both current registers are reloaded from the base values rather than cleared. It also checks that an external end of process never sets a status bit. For the two same-cycle collisions, a status read against a fresh terminal count and a write against a strobe, the side that must win is checked at the ports.

// File: rtl/dmau_pkg.sv
package dmau_pkg;
   typedef struct packed {
      logic dec;
      logic autoi;
   } chan_mode_t;

   localparam chan_mode_t MODE_RESET = '{dec: 1'b0, autoi: 1'b0};
endpackage

// File: rtl/dmau_chan.sv
module dmau_chan
   import dmau_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_addr,
   input  logic          ld_cnt,
   input  logic [AW-1:0] ld_a_val,
   input  logic [CW-1:0] ld_c_val,
   input  logic          mode_ld,
   input  chan_mode_t    mode_in,
   input  logic          step,
   input  logic          end_ext,
   output logic [AW-1:0] cur_addr,
   output logic [CW-1:0] cur_cnt,
   output logic          tc_hit,
   output logic          fin,
   output logic          autoi
);
   logic [AW-1:0] base_addr;
   logic [CW-1:0] base_cnt;
   chan_mode_t    mode_q;
   logic [AW-1:0] addr_next;

   assign tc_hit    = step && (cur_cnt == '0);
   assign fin       = step && (tc_hit || end_ext);
   assign autoi     = mode_q.autoi;
   assign addr_next = mode_q.dec ? cur_addr - AW'(1) : cur_addr + AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_RESET;
         base_addr <= '0;
         base_cnt  <= '0;
         cur_addr  <= '0;
         cur_cnt   <= '0;
      end else begin
         if (mode_ld) mode_q <= mode_in;
         if (ld_addr) begin
            base_addr <= ld_a_val;
            cur_addr  <= ld_a_val;
         end else if (step) begin
            cur_addr  <= (fin && mode_q.autoi) ? base_addr : addr_next;
         end
         if (ld_cnt) begin
            base_cnt  <= ld_c_val;
            cur_cnt   <= ld_c_val;
         end else if (step) begin
            cur_cnt   <= (fin && mode_q.autoi) ? base_cnt : cur_cnt - CW'(1);
         end
      end
   end

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !fin && !ld_cnt) |=> (cur_cnt == $past(cur_cnt) - CW'(1)));

   assert_addr_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !fin && !ld_addr && !mode_ld) |=>
         (cur_addr == ($past(mode_q.dec) ? $past(cur_addr) - AW'(1) : $past(cur_addr) + AW'(1))));

   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && autoi && !ld_cnt && !ld_addr) |=> (cur_cnt == base_cnt && cur_addr == base_addr));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !ld_cnt && !ld_addr) |=> $stable(cur_cnt) && $stable(cur_addr));
endmodule

// File: rtl/dma_addr_count_unit.sv
module dma_addr_count_unit
   import dmau_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int AW     = 16,
   parameter int CW     = 16,
   localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int DW    = (AW > CW) ? AW : CW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CHW-1:0]    wr_ch,
   input  logic              wr_sel,
   input  logic [DW-1:0]     wr_data,
   input  logic              mode_wr,
   input  logic [CHW-1:0]    mode_ch,
   input  logic              mode_dec,
   input  logic              mode_auto,
   input  logic [NUM_CH-1:0] mask_clr,
   input  logic              stat_rd,
   input  logic [CHW-1:0]    svc_ch,
   input  logic              xfer_stb,
   input  logic              ext_eop,
   output logic [AW-1:0]     addr_out,
   output logic [CW-1:0]     cnt_out,
   output logic              eop_out,
   output logic [NUM_CH-1:0] tc_status,
   output logic [NUM_CH-1:0] mask_out
);
   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("NUM_CH out of range");
   end
   if (AW < 4 || CW < 2) begin : g_bad_w
      $error("AW/CW too small");
   end

   logic [AW-1:0] ca [NUM_CH];
   logic [CW-1:0] cc [NUM_CH];
   logic [NUM_CH-1:0] tc_v, fin_v, auto_v, step_v;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit_wr, hit_md;
      assign hit_wr    = wr_en && (wr_ch == CHW'(i));
      assign hit_md    = mode_wr && (mode_ch == CHW'(i));
      assign step_v[i] = xfer_stb && (svc_ch == CHW'(i)) && !hit_wr;

      dmau_chan #(.AW(AW), .CW(CW)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .ld_addr  (hit_wr && !wr_sel),
         .ld_cnt   (hit_wr && wr_sel),
         .ld_a_val (wr_data[AW-1:0]),
         .ld_c_val (wr_data[CW-1:0]),
         .mode_ld  (hit_md),
         .mode_in  ('{dec: mode_dec, autoi: mode_auto}),
         .step     (step_v[i]),
         .end_ext  (ext_eop),
         .cur_addr (ca[i]),
         .cur_cnt  (cc[i]),
         .tc_hit   (tc_v[i]),
         .fin      (fin_v[i]),
         .autoi    (auto_v[i])
      );
   end

   assign addr_out = ca[svc_ch];
   assign cnt_out  = cc[svc_ch];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_out  <= '1;
         tc_status <= '0;
         eop_out   <= 1'b0;
      end else begin
         mask_out  <= (mask_out & ~mask_clr) | (fin_v & ~auto_v);
         tc_status <= (stat_rd ? '0 : tc_status) | tc_v;
         eop_out   <= |fin_v;
      end
   end

   assert_eop_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eop_out |-> $past(xfer_stb));

   assert_eop_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eop_out && !xfer_stb) |=> !eop_out);

   assert_tc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !xfer_stb) |=> (tc_status == '0));

   assert_mask_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(mask_out & ~$past(mask_out))) |-> $past(xfer_stb));

   assert_ext_no_tc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_v == '0 && !stat_rd) |=> $stable(tc_status));
endmodule

// File: tb/dma_addr_count_unit_test.sv
module dma_addr_count_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 0, wr_sel = 0, mode_wr = 0, mode_dec = 0, mode_auto = 0;
   logic [1:0]  wr_ch = 0, mode_ch = 0, svc_ch = 0;
   logic [15:0] wr_data = 0;
   logic [3:0]  mask_clr = 0;
   logic        stat_rd = 0, xfer_stb = 0, ext_eop = 0;
   logic [15:0] addr_out, cnt_out;
   logic        eop_out;
   logic [3:0]  tc_status, mask_out;
   int checks = 0, failures = 0;

   always #4 clk = ~clk;

   dma_addr_count_unit uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
      .wr_data(wr_data), .mode_wr(mode_wr), .mode_ch(mode_ch), .mode_dec(mode_dec),
      .mode_auto(mode_auto), .mask_clr(mask_clr), .stat_rd(stat_rd), .svc_ch(svc_ch),
      .xfer_stb(xfer_stb), .ext_eop(ext_eop), .addr_out(addr_out), .cnt_out(cnt_out),
      .eop_out(eop_out), .tc_status(tc_status), .mask_out(mask_out));

   // kind[49:48] 0=write addr 1=write count 2=strobe; data; expected addr; expected count
   localparam logic [49:0] VEC [5] = '{
      {2'd0, 16'h1000, 16'h1000, 16'h0000},
      {2'd1, 16'h0002, 16'h1000, 16'h0002},
      {2'd2, 16'h0000, 16'h1001, 16'h0001},
      {2'd2, 16'h0000, 16'h1002, 16'h0000},
      {2'd2, 16'h0000, 16'h1003, 16'hFFFF}
   };

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clk_in();
      @(posedge clk); #1;
      wr_en = 0; mode_wr = 0; xfer_stb = 0; ext_eop = 0; stat_rd = 0; mask_clr = 0;
   endtask

   task automatic wr(input logic [1:0] ch, input logic sel, input logic [15:0] d);
      @(negedge clk); wr_en = 1; wr_ch = ch; wr_sel = sel; wr_data = d; clk_in();
   endtask

   task automatic md(input logic [1:0] ch, input logic dec, input logic au);
      @(negedge clk); mode_wr = 1; mode_ch = ch; mode_dec = dec; mode_auto = au; clk_in();
   endtask

   task automatic stb(input logic [1:0] ch, input logic eop, input logic rd);
      @(negedge clk); svc_ch = ch; xfer_stb = 1; ext_eop = eop; stat_rd = rd; clk_in();
   endtask

   task automatic unmask(input logic [3:0] m);
      @(negedge clk); mask_clr = m; clk_in();
   endtask

   initial begin
      #1_000_000;
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 mask", 32'(mask_out), 32'hF);
      chk("R1 tc", 32'(tc_status), 32'h0);
      chk("R1 eop", 32'(eop_out), 32'h0);
      chk("R1 addr/cnt", {addr_out, cnt_out}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // table on channel 1, increment, no autoinitialize
      md(2'd1, 1'b0, 1'b0);
      unmask(4'b0010);
      chk("R11 mask clear", 32'(mask_out), 32'hD);
      for (int i = 0; i < 5; i++) begin
         case (VEC[i][49:48])
            2'd0: wr(2'd1, 1'b0, VEC[i][47:32]);
            2'd1: wr(2'd1, 1'b1, VEC[i][47:32]);
            default: stb(2'd1, 1'b0, 1'b0);
         endcase
         svc_ch = 2'd1; #1;
         chk("R2/R3/R4 table", {addr_out, cnt_out}, {VEC[i][31:16], VEC[i][15:0]});
      end
      chk("R5 tc bit", 32'(tc_status), 32'h2);
      chk("R5 eop high", 32'(eop_out), 32'h1);
      chk("R7 mask set", 32'(mask_out), 32'hF);
      @(posedge clk); #1;
      chk("R5 eop one cycle", 32'(eop_out), 32'h0);
      repeat (4) @(posedge clk); #1;
      chk("R10 hold", {addr_out, cnt_out}, 32'h1003FFFF);
      svc_ch = 2'd0; #1;
      chk("R10 other channel", {addr_out, cnt_out}, 32'h0);

      @(negedge clk); stat_rd = 1; clk_in();
      chk("R9 clear", 32'(tc_status), 32'h0);

      // channel 2: decrement, autoinitialize
      md(2'd2, 1'b1, 1'b1);
      unmask(4'b0100);
      wr(2'd2, 1'b0, 16'h0005);
      wr(2'd2, 1'b1, 16'h0001);
      stb(2'd2, 1'b0, 1'b0);
      chk("R4 decrement", {addr_out, cnt_out}, 32'h00040000);
      stb(2'd2, 1'b0, 1'b0);
      chk("R6 reload", {addr_out, cnt_out}, 32'h00050001);
      chk("R6 mask kept", 32'(mask_out), 32'hB);
      chk("R5 tc ch2", 32'(tc_status), 32'h4);

      // channel 3: decrement wrap, then external end of process
      md(2'd3, 1'b1, 1'b0);
      unmask(4'b1000);
      wr(2'd3, 1'b1, 16'h0010);
      stb(2'd3, 1'b0, 1'b0);
      chk("R4 wrap", {addr_out, cnt_out}, 32'hFFFF000F);
      stb(2'd3, 1'b1, 1'b0);
      chk("R8 step", {addr_out, cnt_out}, 32'hFFFE000E);
      chk("R8 eop", 32'(eop_out), 32'h1);
      chk("R8 no tc", 32'(tc_status), 32'h4);
      chk("R8 mask", 32'(mask_out), 32'hB);

      // same-cycle status read and terminal count on channel 0
      stb(2'd0, 1'b0, 1'b1);
      chk("R9 set wins", 32'(tc_status), 32'h1);

      // write beats strobe
      @(negedge clk);
      svc_ch = 2'd0; xfer_stb = 1; wr_en = 1; wr_ch = 2'd0; wr_sel = 1; wr_data = 16'h0042;
      clk_in();
      chk("R12 write wins", 32'(cnt_out), 32'h42);
      chk("R12 addr untouched", 32'(addr_out), 32'h1);

      // mask set beats mask clear
      md(2'd1, 1'b0, 1'b0);
      wr(2'd1, 1'b1, 16'h0000);
      @(negedge clk); svc_ch = 2'd1; xfer_stb = 1; mask_clr = 4'b0010; clk_in();
      chk("R11 set wins", 32'(mask_out[1]), 32'h1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule